// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns a single burst request into a stream of per-transfer addresses for a master/slave on-chip socket with split request and response phases. A master presents a start address, a burst kind code, a length, a precise/imprecise flag and a transfer size once. The generator then produces one address per transfer over a valid/accept handshake, so one request phase is followed by many data beats. The burst kind code travels with every transfer, and the final transfer is marked.

Four address orderings are built in: a linear increment, a wrap inside an aligned power-of-two block, a fixed streaming address, and an XOR ordering that delivers the critical word first and then visits the rest of the block. In a precise burst the length is known when the burst starts. In an imprecise burst the master supplies a fresh remaining-length hint with each beat, and the burst ends when that hint reads one.

Top module: `burst_addr_gen`

## Requirements
- R1: `reqReady` is high exactly when no burst is active. A request is taken on a cycle where `reqValid` and `reqReady` are both high. The first transfer is valid on the next cycle and carries the start address. A request presented while a burst is active is ignored.
- R2: While `xferValid` is high and `xferAccept` is low, `xferAddr`, `xferType` and `xferValid` hold. Each cycle with both high completes one beat.
- R3: Kind code 0 (incrementing): beat k has address start + k·2^size, where the transfer size in bytes is 2^`reqSize`.
- R4: Kind code 1 (wrapping) with a power-of-two length L: beat k has address base + ((start + k·2^size) mod B). Here B = L·2^size and base is start rounded down to a multiple of B.
- R5: Kind code 2 (streaming): every beat carries the start address.
- R6: Kind code 3 (XOR) with a power-of-two length L: beat k has address base + ((start mod B) XOR (k·2^size mod B)), with B and base as in R4.
- R7: Kind codes 4 to 7 behave as code 0. Codes 1 and 3 with a length that is not a power of two (including 0) also behave as code 0.
- R8: A precise burst (`reqPrecise`=1) of length L makes exactly max(L,1) transfers, and `xferLast` is high only on the final one.
- R9: In an imprecise burst (`reqPrecise`=0), `xferLast` follows the current `beatLen` and is high exactly when `beatLen` equals 1. The block size B for codes 1 and 3 comes from `reqLen` as taken with the request.
- R10: `xferType` carries the 3-bit kind code as it was presented with the request, on every transfer.
- R11: In the cycle after the last transfer is accepted, `xferValid` is low and `reqReady` is high.
- R12: During and just after reset, `xferValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request present |
| reqReady | output | 1 | Generator idle, request can be taken |
| reqAddr | input | ADDR_W | Start byte address |
| reqType | input | 3 | Burst kind code |
| reqLen | input | LEN_W | Burst length in transfers |
| reqPrecise | input | 1 | 1 = length known, 0 = imprecise |
| reqSize | input | SIZE_W | log2 of transfer size in bytes |
| beatLen | input | LEN_W | Remaining-length hint, read on each beat of an imprecise burst |
| xferValid | output | 1 | Transfer address valid |
| xferAccept | input | 1 | Consumer takes the current transfer |
| xferAddr | output | ADDR_W | Address of the current transfer |
| xferType | output | 3 | Kind code of the burst in progress |
| xferLast | output | 1 | Current transfer is the final one |

## Verification
Every cycle, the assertions check these rules: the handshake hold rule, idle-only request acceptance, the start address on the first beat, the streaming address, the incrementing step, the precise beat count against `xferLast`, the kind code on each transfer, and the return to idle. The exact wrap and XOR orderings, the fallback of odd codes and non-power-of-two lengths, the imprecise termination driven by `beatLen`, and the case of a request ignored while busy are shown only by the bench scenarios. In those scenarios a behavioural model predicts every address and last flag cycle by cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Effective address ordering after code decode and length qualification
  typedef enum logic [1:0] {
    SEQ_INCR   = 2'd0,
    SEQ_WRAP   = 2'd1,
    SEQ_STREAM = 2'd2,
    SEQ_XOR    = 2'd3
  } seqKindE;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } dpCtrlS;

  // Raw 3-bit code to ordering; block orderings need a power-of-two length (R7)
  function automatic seqKindE decodeKind(input logic [2:0] code, input logic lenPow2);
    seqKindE k;
    case (code)
      3'd1:    k = lenPow2 ? SEQ_WRAP : SEQ_INCR;
      3'd2:    k = SEQ_STREAM;
      3'd3:    k = lenPow2 ? SEQ_XOR : SEQ_INCR;
      default: k = SEQ_INCR;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             xferAccept,
  input  logic [LEN_W-1:0] beatLen,
  input  logic [LEN_W-1:0] curLen,
  input  logic             curPrecise,
  output logic             reqReady,
  output logic             xferValid,
  output logic             xferLast,
  output dpCtrlS           dpCtrl
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             busyQ;
  logic [LEN_W-1:0] beatQ;
  logic             lastPrecise;
  logic             lastImprecise;
  logic             beatDone;

  // Precise: count against the captured length; zero or one means single beat
  assign lastPrecise   = (curLen <= ONE) ? 1'b1 : (beatQ == (curLen - ONE));
  // Imprecise: hint read live on the current beat
  assign lastImprecise = (beatLen == ONE);

  assign reqReady  = !busyQ;
  assign xferValid = busyQ;
  assign xferLast  = busyQ && (curPrecise ? lastPrecise : lastImprecise);
  assign beatDone  = busyQ && xferAccept;

  always_comb begin
    dpCtrl         = '0;
    dpCtrl.load    = reqValid && !busyQ;
    dpCtrl.advance = beatDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      beatQ <= '0;
    end else if (dpCtrl.load) begin
      busyQ <= 1'b1;
      beatQ <= '0;
    end else if (beatDone) begin
      if (xferLast) begin
        busyQ <= 1'b0;
      end
      beatQ <= beatQ + ONE;
    end
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlS            dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqType,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqPrecise,
  input  logic [SIZE_W-1:0] reqSize,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [2:0]        xferType,
  output logic [LEN_W-1:0]  curLen,
  output logic              curPrecise
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] offsQ;
  logic [ADDR_W-1:0] maskQ;
  logic [ADDR_W-1:0] stepQ;
  logic [2:0]        codeQ;
  logic [LEN_W-1:0]  lenQ;
  logic              precQ;
  seqKindE           seqQ;

  logic              lenPow2;
  logic [ADDR_W-1:0] blockBytes;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] linAddr;

  // Block geometry is settled at load so the per-beat path stays shallow
  assign lenPow2    = (reqLen != '0) && ((reqLen & (reqLen - LEN_W'(1))) == '0);
  assign blockBytes = ADDR_W'(reqLen) << reqSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      offsQ  <= '0;
      maskQ  <= '0;
      stepQ  <= '0;
      codeQ  <= '0;
      lenQ   <= '0;
      precQ  <= 1'b0;
      seqQ   <= SEQ_INCR;
    end else if (dpCtrl.load) begin
      startQ <= reqAddr;
      offsQ  <= '0;
      maskQ  <= blockBytes - ADDR_ONE;
      stepQ  <= ADDR_ONE << reqSize;
      codeQ  <= reqType;
      lenQ   <= reqLen;
      precQ  <= reqPrecise;
      seqQ   <= decodeKind(reqType, lenPow2);
    end else if (dpCtrl.advance) begin
      offsQ  <= offsQ + stepQ;
    end
  end

  assign baseAddr = startQ & ~maskQ;
  assign linAddr  = startQ + offsQ;

  always_comb begin
    case (seqQ)
      SEQ_WRAP:   xferAddr = baseAddr | (linAddr & maskQ);
      SEQ_STREAM: xferAddr = startQ;
      SEQ_XOR:    xferAddr = baseAddr | ((startQ ^ offsQ) & maskQ);
      default:    xferAddr = linAddr;
    endcase
  end

  assign xferType   = codeQ;
  assign curLen     = lenQ;
  assign curPrecise = precQ;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqType,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqPrecise,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [LEN_W-1:0]  beatLen,
  output logic              xferValid,
  input  logic              xferAccept,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [2:0]        xferType,
  output logic              xferLast
);

  localparam int MAX_SHIFT = (1 << SIZE_W) - 1;

  generate
    if (ADDR_W <= LEN_W + MAX_SHIFT) begin : g_badWidth
      $error("ADDR_W too narrow for the largest burst block");
    end
  endgenerate

  dpCtrlS           dpCtrl;
  logic [LEN_W-1:0] curLen;
  logic             curPrecise;

  burst_addr_ctrl #(
    .LEN_W(LEN_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .xferAccept(xferAccept),
    .beatLen   (beatLen),
    .curLen    (curLen),
    .curPrecise(curPrecise),
    .reqReady  (reqReady),
    .xferValid (xferValid),
    .xferLast  (xferLast),
    .dpCtrl    (dpCtrl)
  );

  burst_addr_dp #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SIZE_W(SIZE_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .reqAddr   (reqAddr),
    .reqType   (reqType),
    .reqLen    (reqLen),
    .reqPrecise(reqPrecise),
    .reqSize   (reqSize),
    .xferAddr  (xferAddr),
    .xferType  (xferType),
    .curLen    (curLen),
    .curPrecise(curPrecise)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [2:0]        reqType,
  input logic [LEN_W-1:0]  reqLen,
  input logic              reqPrecise,
  input logic [SIZE_W-1:0] reqSize,
  input logic              xferValid,
  input logic              xferAccept,
  input logic [ADDR_W-1:0] xferAddr,
  input logic [2:0]        xferType,
  input logic              xferLast
);

  logic [ADDR_W-1:0] startC;
  logic [SIZE_W-1:0] sizeC;
  logic [2:0]        codeC;
  logic [LEN_W:0]    lenC;
  logic [LEN_W:0]    cntC;
  logic              precC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startC <= '0;
      sizeC  <= '0;
      codeC  <= '0;
      lenC   <= '0;
      cntC   <= '0;
      precC  <= 1'b0;
    end else if (reqValid && reqReady) begin
      startC <= reqAddr;
      sizeC  <= reqSize;
      codeC  <= reqType;
      lenC   <= {1'b0, reqLen};
      cntC   <= '0;
      precC  <= reqPrecise;
    end else if (xferValid && xferAccept) begin
      cntC   <= cntC + 1'b1;
    end
  end

  a_r12_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!xferValid && reqReady));

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> !reqReady);

  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (xferValid && xferAddr == $past(reqAddr)));

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferAccept) |=> (xferValid && $stable(xferAddr) && $stable(xferType)));

  a_r3_incr_step: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferAccept && !xferLast && codeC == 3'd0)
      |=> (xferAddr == $past(xferAddr) + (ADDR_W'(1) << sizeC)));

  a_r5_stream_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && codeC == 3'd2) |-> (xferAddr == startC));

  a_r8_precise_last: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && precC) |-> (xferLast == ((cntC + 1'b1) >= lenC)));

  a_r10_code_carried: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (xferType == codeC));

  a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferAccept && xferLast) |=> (!xferValid && reqReady));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W),
  .SIZE_W(SIZE_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqType   (reqType),
  .reqLen    (reqLen),
  .reqPrecise(reqPrecise),
  .reqSize   (reqSize),
  .xferValid (xferValid),
  .xferAccept(xferAccept),
  .xferAddr  (xferAddr),
  .xferType  (xferType),
  .xferLast  (xferLast)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;
  localparam int SIZE_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2:0]        reqType = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              reqPrecise = 1'b0;
  logic [SIZE_W-1:0] reqSize = '0;
  logic [LEN_W-1:0]  beatLen = '0;
  logic              xferValid;
  logic              xferAccept = 1'b0;
  logic [ADDR_W-1:0] xferAddr;
  logic [2:0]        xferType;
  logic              xferLast;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqType(reqType), .reqLen(reqLen), .reqPrecise(reqPrecise),
    .reqSize(reqSize), .beatLen(beatLen), .xferValid(xferValid),
    .xferAccept(xferAccept), .xferAddr(xferAddr), .xferType(xferType),
    .xferLast(xferLast)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference state
  bit     mBusy = 0;
  int     mK = 0;
  longint mStart = 0;
  int     mCode = 0, mLen = 0, mSize = 0;
  bit     mPrec = 0;

  function automatic bit isPow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int effKind();
    if (mCode > 3) return 0;
    if ((mCode == 1 || mCode == 3) && !isPow2(mLen)) return 0;
    return mCode;
  endfunction

  function automatic string addrTag();
    int e = effKind();
    if (e != mCode) return "R7";
    case (e)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic longint expAddr(int k);
    longint sz = longint'(1) << mSize;
    longint off = k * sz;
    longint blk = mLen * sz;
    longint base, a;
    case (effKind())
      1: begin base = mStart - (mStart % blk); a = base + ((mStart + off) % blk); end
      2: a = mStart;
      3: begin base = mStart - (mStart % blk); a = base + ((mStart % blk) ^ (off % blk)); end
      default: a = mStart + off;
    endcase
    return a & 64'hFFFF_FFFF;
  endfunction

  function automatic bit expLast(int k, int bl);
    if (mPrec) return k >= (((mLen == 0) ? 1 : mLen) - 1);
    return bl == 1;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model advances on the clock using only bench-driven inputs
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0;
    end else if (!mBusy) begin
      if (reqValid) begin
        mBusy = 1; mK = 0; mStart = longint'(reqAddr); mCode = int'(reqType);
        mLen = int'(reqLen); mSize = int'(reqSize); mPrec = reqPrecise;
      end
    end else if (xferAccept) begin
      if (expLast(mK, int'(beatLen))) mBusy = 0;
      else mK++;
    end
  end

  // Compare every cycle, well after inputs settle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      #2;
      check("R1/R11", "reqReady", longint'(reqReady), longint'(!mBusy));
      check("R2", "xferValid", longint'(xferValid), longint'(mBusy));
      if (mBusy && xferValid) begin
        check(addrTag(), "xferAddr", longint'(xferAddr), expAddr(mK));
        check(mPrec ? "R8" : "R9", "xferLast", longint'(xferLast),
              longint'(expLast(mK, int'(beatLen))));
        check("R10", "xferType", longint'(xferType), longint'(mCode));
      end
    end
  end

  task automatic runBurst(input logic [31:0] a, input int code, input int len,
                          input bit prec, input int size, input bit stall,
                          input int remain, input bit poke);
    int n = 0;
    int cyc = 0;
    bit done = 0;
    bit hs, lst;
    @(negedge clk);
    reqAddr = a; reqType = 3'(code); reqLen = LEN_W'(len);
    reqPrecise = prec; reqSize = SIZE_W'(size); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqLen = LEN_W'(len + 1); reqType = 3'(code + 1);
    while (!done) begin
      beatLen = prec ? '0 : LEN_W'(remain - n);
      xferAccept = stall ? ((cyc % 3) != 1) : 1'b1;
      reqValid = poke && (n == 0);   // R1: ignored while busy
      #1;
      hs = xferValid && xferAccept;
      lst = hs && xferLast;
      @(negedge clk);
      cyc++;
      if (hs) n++;
      if (lst) done = 1;
    end
    reqValid = 1'b0;
    xferAccept = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "xferValid in reset", longint'(xferValid), 0);
    check("R12", "reqReady in reset", longint'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check("R12", "xferValid after reset", longint'(xferValid), 0);
    check("R12", "reqReady after reset", longint'(reqReady), 1);

    runBurst(32'h0000_0100, 0, 4, 1, 2, 0, 0, 0);   // R3 plain increment
    runBurst(32'h0000_0203, 0, 5, 1, 0, 1, 0, 0);   // R3 bytes, stalls (R2)
    runBurst(32'h0000_1008, 1, 4, 1, 2, 0, 0, 0);   // R4 wrap
    runBurst(32'h0000_3038, 1, 8, 1, 3, 1, 0, 0);   // R4 wrap with stalls
    runBurst(32'h0000_4444, 2, 3, 1, 2, 1, 0, 0);   // R5 stream
    runBurst(32'h0000_2004, 3, 4, 1, 2, 0, 0, 0);   // R6 XOR
    runBurst(32'h0000_500A, 3, 8, 1, 1, 1, 0, 0);   // R6 XOR halfwords
    runBurst(32'h0000_6000, 5, 3, 1, 2, 0, 0, 0);   // R7 unknown code
    runBurst(32'h0000_7004, 1, 3, 1, 2, 0, 0, 0);   // R7 wrap with odd length
    runBurst(32'h0000_7104, 3, 0, 1, 2, 0, 0, 0);   // R7/R8 XOR length zero
    runBurst(32'h0000_8000, 0, 1, 1, 3, 0, 0, 1);   // R8 single, R1 poke
    runBurst(32'h0000_9000, 0, 63, 1, 0, 0, 0, 0);  // R8 maximum length
    runBurst(32'h0000_A010, 0, 2, 0, 2, 1, 6, 0);   // R9 imprecise increment
    runBurst(32'h0000_B00C, 1, 4, 0, 2, 0, 7, 1);   // R9 imprecise wrap, R1 poke
    runBurst(32'h0000_C006, 3, 4, 0, 1, 1, 5, 0);   // R9 imprecise XOR
    runBurst(32'h0000_D000, 2, 9, 0, 2, 0, 1, 0);   // R9 imprecise single beat
    repeat (3) @(negedge clk);
    #2;
    check("R11", "idle at end", longint'(reqReady && !xferValid), 1);
    summary();
  end

endmodule